// File: doc/BRIEF.md
# Parallel Programming Host Sequencer

This block is the host side of a high-voltage parallel programming link to a microcontroller. It takes one command at a time from a user port and turns it into a timed pattern on the target's pins. The pins are a clock strobe that latches bytes, a page-load strobe, two byte-select lines, an active-low write strobe and an active-low output enable. It also drives or samples an 8-bit data bus and watches a ready/busy input. The command set is: load a byte, pulse a page load, program (write), chip erase and read a byte. Programming-voltage control and the meaning of each command byte are left to the user.

Every analog minimum time is a parameter in nanoseconds. The block converts each one to a whole number of system clock cycles by rounding up against a clock-period parameter. The two busy-completion limits are parameters given directly in cycles. The data bus is split into `pp_data_o`, `pp_data_oe` and `pp_data_i`, and a pad at chip level joins them into one bidirectional bus.

Both user interfaces use valid/ready handshakes. A command is taken on a cycle where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is high only when the sequencer is idle. Every command gives exactly one response. The response stays on `rsp_valid`, `rsp_data` and `rsp_err` without change until `rsp_ready` takes it, and no new command is accepted before then. This means a slow consumer stalls the sequencer but loses nothing.

Top module: `pp_host_seq`

## Requirements
- R1: After reset, both strobes are low, `pp_wr_n` and `pp_oe_n` are high, `pp_data_oe` is low, `cmd_ready` is high and `rsp_valid` is low.
- R2: `cmd_ready` is low from the cycle after a command is taken until its response is consumed. A response held back by a low `rsp_ready` keeps `rsp_valid`, `rsp_data` and `rsp_err` unchanged.
- R3: Load (`cmd_op` 0) works as follows. The data byte and the select lines (`cmd_bs` bit 0 drives `pp_sel_lo`, bit 1 drives `pp_sel_hi`) are driven and stable for at least ceil(67 ns) cycles before the clock strobe rises. The strobe stays high for at least ceil(150 ns) cycles. Data and selects do not change while it is high.
- R4: Page pulse (`cmd_op` 1) holds the page strobe high for at least ceil(150 ns) cycles, with the selects stable throughout. After the strobe falls, at least ceil(67 ns) cycles pass before the write strobe can go low.
- R5: Write (`cmd_op` 2) holds `pp_wr_n` low for at least ceil(150 ns) cycles. Once `pp_ready` has gone low and then returned high, the response reports `rsp_err` = 0.
- R6: If `pp_ready` does not go low within ceil(1000 ns) cycles of the write strobe falling, the response reports `rsp_err` = 1.
- R7: If `pp_ready` stays low past the busy limit, the response reports `rsp_err` = 1 and the sequencer returns to idle (`cmd_ready` high again).
- R8: Chip erase (`cmd_op` 3) uses the erase limit `ER_TMO_CYC` in place of the write limit `WR_TMO_CYC`. A busy period between the two limits passes for an erase and fails for a write.
- R9: For a read (`cmd_op` 4), the host turns off its bus drivers before `pp_oe_n` goes low and never drives while it is low. It samples `pp_data_i` ceil(350 ns)+1 cycles after the falling edge and returns that byte in `rsp_data`.
- R10: Op codes 5 to 7 are answered with `rsp_err` = 1 and cause no edge on any strobe or on `pp_oe_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Sequencer idle, command can be taken |
| cmd_op | input | 3 | 0 load, 1 page, 2 write, 3 erase, 4 read |
| cmd_bs | input | 2 | Byte-select values, bit 0 low select, bit 1 high select |
| cmd_data | input | 8 | Byte for a load |
| rsp_valid | output | 1 | Response available |
| rsp_ready | input | 1 | Response consumed |
| rsp_data | output | 8 | Byte read, zero for other commands |
| rsp_err | output | 1 | Busy handshake fault or unknown op |
| pp_clk_strobe | output | 1 | Byte-latch clock strobe to target |
| pp_page_strobe | output | 1 | Page-load strobe to target |
| pp_sel_lo | output | 1 | Low byte-select line |
| pp_sel_hi | output | 1 | High byte-select line |
| pp_wr_n | output | 1 | Write strobe, active low |
| pp_oe_n | output | 1 | Output enable, active low |
| pp_data_o | output | 8 | Bus value driven by host |
| pp_data_oe | output | 1 | Host bus driver enable |
| pp_data_i | input | 8 | Bus value from target |
| pp_ready | input | 1 | Target ready (high) / busy (low) |

## Verification
The bench goes after the busy handshake corners, where mistakes change the error flag. A write whose busy signal never falls must be flagged, or a dead target would look like it programmed. A busy period longer than the write limit but shorter than the erase limit must fail as a write and pass as an erase, which exposes a sequencer that uses one window for both. A target stuck busy must time out and return to idle, not hang. The read model drives junk until well into the output-enable window, so a host that samples early returns the wrong byte. Pin monitors measure setup, pulse widths and bus overlap, which catches a shortened phase or a host that drives the bus during a read.

// File: rtl/pp_pkg.sv
package pp_pkg;

  typedef enum logic [2:0] {
    OP_LOAD  = 3'd0,
    OP_PAGE  = 3'd1,
    OP_WRITE = 3'd2,
    OP_ERASE = 3'd3,
    OP_READ  = 3'd4
  } pp_op_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_LD_SETUP, ST_LD_HIGH, ST_LD_HOLD,
    ST_PG_SETUP, ST_PG_HIGH, ST_PG_HOLD,
    ST_WR_SETUP, ST_WR_LOW, ST_WR_BUSY, ST_WR_HOLD,
    ST_RD_TURN, ST_RD_OE, ST_RD_REL, ST_RESP
  } pp_state_e;

  // nanoseconds to clock cycles, rounded up
  function automatic int ns_to_cyc(input int ns, input int clk_ps);
    longint num;
    num = longint'(ns) * 64'sd1000 + longint'(clk_ps) - 64'sd1;
    return int'(num / longint'(clk_ps));
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pp_phase_timer.sv
module pp_phase_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (load)         cnt <= val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/pp_busy_watch.sv
module pp_busy_watch #(
  parameter int LOWBY  = 200,
  parameter int WR_LIM = 700000,
  parameter int ER_LIM = 2200000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic erase,
  input  logic rdy,
  output logic fin,
  output logic err
);
  localparam int LIM_MAX = (ER_LIM > WR_LIM) ? ER_LIM : WR_LIM;
  localparam int CW      = $clog2(LIM_MAX + 1);

  logic          active, seen, er_q;
  logic [CW-1:0] cnt, lim;

  assign lim = er_q ? CW'(ER_LIM - 1) : CW'(WR_LIM - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0; seen <= 1'b0; er_q <= 1'b0;
      fin <= 1'b0; err <= 1'b0; cnt <= '0;
    end else if (start) begin
      active <= 1'b1; seen <= 1'b0; er_q <= erase;
      fin <= 1'b0; err <= 1'b0; cnt <= '0;
    end else if (active) begin
      cnt <= cnt + 1'b1;
      if (!rdy) seen <= 1'b1;
      if (seen && rdy) begin
        active <= 1'b0; fin <= 1'b1;
      end else if (!seen && rdy && cnt >= CW'(LOWBY - 1)) begin
        active <= 1'b0; fin <= 1'b1; err <= 1'b1;
      end else if (cnt >= lim) begin
        active <= 1'b0; fin <= 1'b1; err <= 1'b1;
      end
    end
  end

  // R5: a clean finish needs the ready line seen high
  p_clean_finish_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(fin) && !err) |-> $past(rdy));

  // R6 / R7: an error finish never happens while the window is still open and busy was seen with ready back high
  p_err_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(fin) && err) |-> !($past(seen) && $past(rdy)));
endmodule

// File: rtl/pp_host_seq.sv
module pp_host_seq
  import pp_pkg::*;
#(
  parameter int CLK_PS     = 5000,
  parameter int SETUP_NS   = 67,
  parameter int HOLD_NS    = 67,
  parameter int XHIGH_NS   = 150,
  parameter int XLOW_NS    = 200,
  parameter int PHIGH_NS   = 150,
  parameter int PL_XH_NS   = 150,
  parameter int PL_WL_NS   = 67,
  parameter int WLOW_NS    = 150,
  parameter int RDYLOW_NS  = 1000,
  parameter int RDV_NS     = 350,
  parameter int REL_NS     = 250,
  parameter int WR_TMO_CYC = 700000,
  parameter int ER_TMO_CYC = 2200000,
  parameter int DW         = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [2:0]    cmd_op,
  input  logic [1:0]    cmd_bs,
  input  logic [DW-1:0] cmd_data,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [DW-1:0] rsp_data,
  output logic          rsp_err,
  output logic          pp_clk_strobe,
  output logic          pp_page_strobe,
  output logic          pp_sel_lo,
  output logic          pp_sel_hi,
  output logic          pp_wr_n,
  output logic          pp_oe_n,
  output logic [DW-1:0] pp_data_o,
  output logic          pp_data_oe,
  input  logic [DW-1:0] pp_data_i,
  input  logic          pp_ready
);
  localparam int T_SETUP  = ns_to_cyc(SETUP_NS, CLK_PS);
  localparam int T_HOLD   = ns_to_cyc(HOLD_NS, CLK_PS);
  localparam int T_XHIGH  = ns_to_cyc(XHIGH_NS, CLK_PS);
  localparam int T_LDHOLD = max2(T_HOLD, ns_to_cyc(XLOW_NS, CLK_PS));
  localparam int T_PHIGH  = ns_to_cyc(PHIGH_NS, CLK_PS);
  localparam int T_PGHOLD = max2(T_HOLD, max2(ns_to_cyc(PL_XH_NS, CLK_PS),
                                              ns_to_cyc(PL_WL_NS, CLK_PS)));
  localparam int T_WLOW   = ns_to_cyc(WLOW_NS, CLK_PS);
  localparam int T_RDYLOW = ns_to_cyc(RDYLOW_NS, CLK_PS);
  localparam int T_RDV    = ns_to_cyc(RDV_NS, CLK_PS) + 1;
  localparam int T_REL    = ns_to_cyc(REL_NS, CLK_PS);
  localparam int T_MAX    = max2(max2(max2(T_SETUP, T_XHIGH), max2(T_LDHOLD, T_PGHOLD)),
                                 max2(max2(T_PHIGH, T_WLOW), max2(T_RDV, T_REL)));
  localparam int TW       = $clog2(T_MAX + 1);

  pp_state_e     state_q, state_d;
  logic          t_load, t_zero;
  logic [TW-1:0] t_val;
  logic          bw_start, bw_fin, bw_err;
  logic          fire, bad_op, er_q, err_q;
  logic [1:0]    bs_q;
  logic [DW-1:0] dout_q, rd_q;

  assign cmd_ready = (state_q == ST_IDLE);
  assign rsp_valid = (state_q == ST_RESP);
  assign rsp_data  = rd_q;
  assign rsp_err   = err_q;
  assign fire      = cmd_valid && cmd_ready;
  assign bad_op    = (cmd_op > 3'd4);
  assign bw_start  = (state_q == ST_WR_SETUP) && t_zero;

  pp_phase_timer #(.W(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(t_load), .val(t_val), .zero(t_zero)
  );

  pp_busy_watch #(.LOWBY(T_RDYLOW), .WR_LIM(WR_TMO_CYC), .ER_LIM(ER_TMO_CYC)) u_busy (
    .clk(clk), .rst_n(rst_n), .start(bw_start), .erase(er_q),
    .rdy(pp_ready), .fin(bw_fin), .err(bw_err)
  );

  always_comb begin
    state_d = state_q;
    t_load  = 1'b0;
    t_val   = '0;
    unique case (state_q)
      ST_IDLE: if (cmd_valid) begin
        t_load = 1'b1;
        t_val  = TW'(T_SETUP - 1);
        case (cmd_op)
          OP_LOAD:  state_d = ST_LD_SETUP;
          OP_PAGE:  state_d = ST_PG_SETUP;
          OP_WRITE,
          OP_ERASE: state_d = ST_WR_SETUP;
          OP_READ:  state_d = ST_RD_TURN;
          default:  state_d = ST_RESP;
        endcase
      end
      ST_LD_SETUP: if (t_zero) begin state_d = ST_LD_HIGH; t_load = 1'b1; t_val = TW'(T_XHIGH - 1);  end
      ST_LD_HIGH:  if (t_zero) begin state_d = ST_LD_HOLD; t_load = 1'b1; t_val = TW'(T_LDHOLD - 1); end
      ST_LD_HOLD:  if (t_zero) state_d = ST_RESP;
      ST_PG_SETUP: if (t_zero) begin state_d = ST_PG_HIGH; t_load = 1'b1; t_val = TW'(T_PHIGH - 1);  end
      ST_PG_HIGH:  if (t_zero) begin state_d = ST_PG_HOLD; t_load = 1'b1; t_val = TW'(T_PGHOLD - 1); end
      ST_PG_HOLD:  if (t_zero) state_d = ST_RESP;
      ST_WR_SETUP: if (t_zero) begin state_d = ST_WR_LOW;  t_load = 1'b1; t_val = TW'(T_WLOW - 1);   end
      ST_WR_LOW:   if (t_zero) state_d = ST_WR_BUSY;
      ST_WR_BUSY:  if (bw_fin) begin state_d = ST_WR_HOLD; t_load = 1'b1; t_val = TW'(T_HOLD - 1);   end
      ST_WR_HOLD:  if (t_zero) state_d = ST_RESP;
      ST_RD_TURN:  if (t_zero) begin state_d = ST_RD_OE;   t_load = 1'b1; t_val = TW'(T_RDV - 1);    end
      ST_RD_OE:    if (t_zero) begin state_d = ST_RD_REL;  t_load = 1'b1; t_val = TW'(T_REL - 1);    end
      ST_RD_REL:   if (t_zero) state_d = ST_RESP;
      ST_RESP:     if (rsp_ready) state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q        <= ST_IDLE;
      pp_clk_strobe  <= 1'b0;
      pp_page_strobe <= 1'b0;
      pp_wr_n        <= 1'b1;
      pp_oe_n        <= 1'b1;
      pp_data_oe     <= 1'b0;
    end else begin
      state_q        <= state_d;
      pp_clk_strobe  <= (state_d == ST_LD_HIGH);
      pp_page_strobe <= (state_d == ST_PG_HIGH);
      pp_wr_n        <= (state_d != ST_WR_LOW);
      pp_oe_n        <= (state_d != ST_RD_OE);
      pp_data_oe     <= (state_d inside {ST_LD_SETUP, ST_LD_HIGH, ST_LD_HOLD});
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bs_q <= '0; dout_q <= '0; rd_q <= '0; err_q <= 1'b0; er_q <= 1'b0;
    end else if (fire) begin
      bs_q   <= cmd_bs;
      dout_q <= cmd_data;
      rd_q   <= '0;
      err_q  <= bad_op;
      er_q   <= (cmd_op == OP_ERASE);
    end else begin
      if (state_q == ST_RD_OE && t_zero)     rd_q  <= pp_data_i;
      if (state_q == ST_WR_BUSY && bw_fin)   err_q <= bw_err;
    end
  end

  assign pp_sel_lo = bs_q[0];
  assign pp_sel_hi = bs_q[1];
  assign pp_data_o = dout_q;

  // width counters used only by the checks below
  int xh_run, pg_run, wl_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xh_run <= 0; pg_run <= 0; wl_run <= 0;
    end else begin
      xh_run <= pp_clk_strobe  ? xh_run + 1 : 0;
      pg_run <= pp_page_strobe ? pg_run + 1 : 0;
      wl_run <= !pp_wr_n       ? wl_run + 1 : 0;
    end
  end

  p_clk_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!pp_clk_strobe && xh_run != 0) |-> xh_run >= T_XHIGH);
  p_clk_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pp_clk_strobe && $past(pp_clk_strobe)) |-> $stable({pp_sel_hi, pp_sel_lo, pp_data_o, pp_data_oe}));
  p_page_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!pp_page_strobe && pg_run != 0) |-> pg_run >= T_PHIGH);
  p_page_sel_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pp_page_strobe && $past(pp_page_strobe)) |-> $stable({pp_sel_hi, pp_sel_lo}));
  p_wr_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pp_wr_n && wl_run != 0) |-> wl_run >= T_WLOW);
  p_no_contention_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(pp_data_oe && !pp_oe_n));
  p_rsp_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_err)));
  p_one_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pp_clk_strobe, pp_page_strobe, !pp_wr_n, !pp_oe_n}));
endmodule

// File: tb/pp_host_seq_tb.sv
module pp_host_seq_tb;
  localparam int WR_TMO = 400;
  localparam int ER_TMO = 1500;

  function automatic int cyc(input int ns);
    return (ns * 1000 + 4999) / 5000;
  endfunction

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, rsp_ready = 1'b0;
  logic [2:0] cmd_op = '0;
  logic [1:0] cmd_bs = '0;
  logic [7:0] cmd_data = '0;
  logic cmd_ready, rsp_valid, rsp_err;
  logic [7:0] rsp_data;
  logic pp_clk_strobe, pp_page_strobe, pp_sel_lo, pp_sel_hi, pp_wr_n, pp_oe_n, pp_data_oe;
  logic [7:0] pp_data_o;
  logic [7:0] pp_data_i = 8'hEE;
  logic pp_ready = 1'b1;

  always #2.5 clk = ~clk;

  pp_host_seq #(.WR_TMO_CYC(WR_TMO), .ER_TMO_CYC(ER_TMO)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_bs(cmd_bs), .cmd_data(cmd_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data), .rsp_err(rsp_err),
    .pp_clk_strobe(pp_clk_strobe), .pp_page_strobe(pp_page_strobe),
    .pp_sel_lo(pp_sel_lo), .pp_sel_hi(pp_sel_hi), .pp_wr_n(pp_wr_n), .pp_oe_n(pp_oe_n),
    .pp_data_o(pp_data_o), .pp_data_oe(pp_data_oe), .pp_data_i(pp_data_i), .pp_ready(pp_ready)
  );

  int n_chk = 0, n_fail = 0;
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // target model
  int mdl_busy = 100;
  bit mdl_nolow = 1'b0;
  logic [7:0] mdl_last = '0;
  function automatic logic [7:0] rd_val(input logic [7:0] last, input logic [1:0] bs);
    return last ^ {6'b0, bs} ^ 8'h3C;
  endfunction

  always @(posedge pp_clk_strobe) mdl_last = pp_data_o;

  initial begin
    forever begin
      @(negedge pp_wr_n);
      if (!mdl_nolow) begin
        repeat (10) @(negedge clk);
        pp_ready = 1'b0;
        repeat (mdl_busy - 10) @(negedge clk);
        pp_ready = 1'b1;
      end
    end
  end

  initial begin
    forever begin
      @(negedge pp_oe_n);
      pp_data_i = 8'hEE;
      repeat (60) @(negedge clk);
      pp_data_i = rd_val(mdl_last, {pp_sel_hi, pp_sel_lo});
      @(posedge pp_oe_n);
      pp_data_i = 8'hEE;
    end
  end

  // pin monitor
  logic [10:0] vec, p_vec = '0;
  bit p_x = 0, p_p = 0, p_w = 1, p_o = 1, overlap = 0;
  int stab = 0, su_meas = 0, xh_c = 0, xh_meas = 0, pg_c = 0, pg_meas = 0;
  int wl_c = 0, wl_meas = 0, gap = 1000, gap_meas = 0;
  int n_xr = 0, n_pr = 0, n_wf = 0, n_of = 0;
  always @(negedge clk) begin
    vec = {pp_data_o, pp_data_oe, pp_sel_hi, pp_sel_lo};
    if (pp_clk_strobe && !p_x) begin su_meas = stab; n_xr++; end
    if (vec == p_vec) stab++; else stab = 1;
    if (pp_clk_strobe) xh_c++; else begin if (p_x) xh_meas = xh_c; xh_c = 0; end
    if (pp_page_strobe) pg_c++; else begin if (p_p) pg_meas = pg_c; pg_c = 0; end
    if (pp_page_strobe && !p_p) n_pr++;
    if (!pp_wr_n && p_w) begin gap_meas = gap; n_wf++; end
    if (pp_page_strobe) gap = 0; else gap++;
    if (!pp_wr_n) wl_c++; else begin if (!p_w) wl_meas = wl_c; wl_c = 0; end
    if (!pp_oe_n && p_o) n_of++;
    if (pp_data_oe && !pp_oe_n) overlap = 1;
    p_vec = vec; p_x = pp_clk_strobe; p_p = pp_page_strobe; p_w = pp_wr_n; p_o = pp_oe_n;
  end

  task automatic do_cmd(input logic [2:0] op, input logic [1:0] bs, input logic [7:0] d,
                        output bit e, output logic [7:0] r);
    int k;
    bit held;
    logic [7:0] hd;
    bit he;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_bs = bs; cmd_data = d;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(cmd_ready == 1'b0, "R2 ready low while busy", int'(cmd_ready), 0);
    while (!rsp_valid) @(negedge clk);
    hd = rsp_data; he = rsp_err; held = 1'b1;
    k = $urandom_range(0, 4);
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      if (!(rsp_valid && rsp_data == hd && rsp_err == he)) held = 1'b0;
    end
    chk(held, "R2 response held under back-pressure", int'(held), 1);
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    e = he; r = hd;
  endtask

  task automatic finish_run();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    bit e;
    logic [7:0] r, exp_last;
    int a, b, c, d;
    void'($urandom(32'd7));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!pp_clk_strobe && !pp_page_strobe && pp_wr_n && pp_oe_n && !pp_data_oe,
        "R1 pins idle after reset", int'({pp_clk_strobe, pp_page_strobe, pp_wr_n, pp_oe_n, pp_data_oe}), 6);
    chk(cmd_ready && !rsp_valid, "R1 handshake idle after reset", int'({cmd_ready, rsp_valid}), 2);

    // R3 load
    do_cmd(3'd0, 2'b00, 8'h5A, e, r);
    exp_last = 8'h5A;
    chk(!e && mdl_last == 8'h5A, "R3 byte latched", int'(mdl_last), 8'h5A);
    chk(su_meas >= cyc(67), "R3 setup before strobe", su_meas, cyc(67));
    chk(xh_meas >= cyc(150), "R3 strobe high width", xh_meas, cyc(150));

    // R4 page then R5 write
    do_cmd(3'd1, 2'b01, 8'h00, e, r);
    chk(!e && pg_meas >= cyc(150), "R4 page strobe width", pg_meas, cyc(150));
    mdl_busy = 250; mdl_nolow = 1'b0;
    do_cmd(3'd2, 2'b01, 8'h00, e, r);
    chk(gap_meas >= cyc(67), "R4 page low before write", gap_meas, cyc(67));
    chk(wl_meas >= cyc(150), "R5 write low width", wl_meas, cyc(150));
    chk(e == 1'b0, "R5 write completes clean", int'(e), 0);

    // R9 read
    do_cmd(3'd4, 2'b10, 8'h00, e, r);
    chk(r == rd_val(exp_last, 2'b10), "R9 read data", int'(r), int'(rd_val(exp_last, 2'b10)));

    // R6 busy never low
    mdl_nolow = 1'b1;
    do_cmd(3'd2, 2'b00, 8'h00, e, r);
    chk(e == 1'b1, "R6 missing busy flagged", int'(e), 1);
    mdl_nolow = 1'b0;

    // R8 busy between the limits
    mdl_busy = 1000;
    do_cmd(3'd2, 2'b00, 8'h00, e, r);
    chk(e == 1'b1, "R8 long busy fails as write", int'(e), 1);
    while (!pp_ready) @(negedge clk);
    do_cmd(3'd3, 2'b00, 8'h00, e, r);
    chk(e == 1'b0, "R8 long busy passes as erase", int'(e), 0);

    // R7 stuck busy
    mdl_busy = 5000;
    do_cmd(3'd3, 2'b00, 8'h00, e, r);
    chk(e == 1'b1, "R7 stuck busy times out", int'(e), 1);
    chk(cmd_ready == 1'b1, "R7 back to idle", int'(cmd_ready), 1);
    while (!pp_ready) @(negedge clk);

    // R10 unknown op
    a = n_xr; b = n_pr; c = n_wf; d = n_of;
    do_cmd(3'd6, 2'b11, 8'hFF, e, r);
    chk(e == 1'b1, "R10 unknown op error", int'(e), 1);
    chk(n_xr == a && n_pr == b && n_wf == c && n_of == d, "R10 no strobe edges",
        n_xr + n_pr + n_wf + n_of, a + b + c + d);

    // random mix
    for (int i = 0; i < 30; i++) begin
      logic [1:0] bs;
      logic [7:0] dv;
      int op;
      op = $urandom_range(0, 3);
      bs = 2'($urandom_range(0, 3));
      dv = 8'($urandom_range(0, 255));
      case (op)
        0: begin
          do_cmd(3'd0, bs, dv, e, r);
          exp_last = dv;
          chk(!e && mdl_last == dv, "R3 random load", int'(mdl_last), int'(dv));
        end
        1: begin
          do_cmd(3'd1, bs, 8'h00, e, r);
          chk(!e && pg_meas >= cyc(150), "R4 random page", pg_meas, cyc(150));
        end
        2: begin
          mdl_busy = $urandom_range(40, 300);
          do_cmd(3'd2, bs, 8'h00, e, r);
          chk(!e && wl_meas >= cyc(150), "R5 random write", int'(e), 0);
        end
        default: begin
          do_cmd(3'd4, bs, 8'h00, e, r);
          chk(r == rd_val(exp_last, bs), "R9 random read", int'(r), int'(rd_val(exp_last, bs)));
        end
      endcase
    end
    chk(overlap == 1'b0, "R9 no bus drive during output enable", int'(overlap), 0);
    finish_run();
  end
endmodule